// File: doc/BRIEF.md
# Slave Port Control and Cold-Boot Sequencer

This block holds the control register of a processor's slave port and runs a small sequencer that decides, right after reset, whether the processor starts normally or waits in a halted cold-boot state. While it waits, an external master loads memory through the slave port. Two external mode pins drive the decision. The pins are synchronized and filtered inside the block. A pin code of `01` seen as reset ends holds the core halted and switches Port A into slave-port mode. A later code of `00` releases the core and emits a single pulse that starts execution at address zero.

Software reaches the register at one fixed internal address over a simple strobe bus. Writes set the Port A mode, the slave interrupt priority and a bit that makes the sequencer stop obeying the pins. Reads return the synchronized state of the mode pins. The rdata pin, the interrupt and the memory traffic of the cold boot are handled elsewhere.

Top module: `sport_ctl`

## Requirements
- R1: While reset is low and after its release, before any decision: port_mode = 00, irq_prio = 00, boot_halt = 0, start_zero = 0, bus_rdata = 0.
- R2: A write (bus_wr = 1) at address 0x24 loads irq_prio from data bits 1:0 (00 = slave interrupt off, 01/10/11 = priority 1/2/3) and, outside cold boot, port_mode from bits 3:2 (00 Port A input, 01 Port A output, 10 slave port, 11 auxiliary bus). Writes at any other address change nothing.
- R3: A read (bus_rd = 1) at address 0x24 gives, one cycle later, bus_rdata = {0, synchronized pins[1:0], 00000}. In every other cycle, and after a read at another address, bus_rdata is 0.
- R4: Mode pins pass through two synchronizing flops. A code is acted on only when two consecutive synchronized samples are equal. So a code held for a single clock is never acted on, and the earliest decision lands on the fourth clock edge after reset release.
- R5: If the first stable code after reset is 01 and the ignore bit is 0, boot_halt rises and port_mode becomes 10 on the same edge.
- R6: If the first stable code after reset is anything else, the block enters normal run. boot_halt stays 0 and start_zero never pulses until the next reset.
- R7: In cold boot with the ignore bit 0, a stable code 00 drops boot_halt and raises start_zero for exactly one cycle on the same edge.
- R8: start_zero pulses at most once per reset, and no pin activity after leaving cold boot brings back boot_halt.
- R9: In cold boot, writes leave port_mode at 10. A port-mode write on the edge that enters cold boot loses to the forced value 10.
- R10: Once data bit 7 = 1 has been written, pin codes no longer move the sequencer: in cold boot it stays halted; before its first decision it goes to normal run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| bus_addr | input | 8 | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after a read strobe |
| mode_pin | input | 2 | External boot-mode pins, asynchronous |
| port_mode | output | 2 | Port A mode select |
| irq_prio | output | 2 | Slave interrupt priority, 0 = disabled |
| boot_halt | output | 1 | High while the core is held in cold boot |
| start_zero | output | 1 | One-cycle pulse: begin execution at address zero |

## Verification
A register write to the port-mode field and a sequencer transition can fall on the same clock edge. The entry into cold boot must override the write, and a write on the exit edge is still blocked. The bench holds a port-mode write asserted on every cycle across reset release, so one of those writes lands on the entry edge. It does the same across the release code in a later run. A behavioural model tracks the pin history and register contents, and predicts every output on every cycle. Any disagreement in port_mode on those edges is reported.

// File: rtl/sport_pkg.sv
package sport_pkg;

  typedef enum logic [1:0] {
    ST_INIT = 2'd0,
    ST_BOOT = 2'd1,
    ST_RUN  = 2'd2
  } boot_st_e;

  localparam logic [1:0] CODE_BOOT = 2'b01;
  localparam logic [1:0] CODE_GO   = 2'b00;

  localparam logic [1:0] PM_IN     = 2'b00;
  localparam logic [1:0] PM_SLAVE  = 2'b10;

  localparam int unsigned IGN_BIT  = 7;
  localparam int unsigned PIN_LSB  = 5;
  localparam int unsigned PM_LSB   = 2;
  localparam int unsigned PRIO_LSB = 0;

endpackage

// File: rtl/sport_pin_filter.sv
module sport_pin_filter #(
  parameter int unsigned W    = 2,
  parameter int unsigned SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] live_o,
  output logic [W-1:0] code_o,
  output logic         code_ok_o
);

  localparam int unsigned VLD_W = SYNC + 1;

  logic [W-1:0]     sync_q [SYNC];
  logic [W-1:0]     hold_q;
  logic [VLD_W-1:0] vld_q;

  // synchronizer chain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q[0] <= '0;
    end else begin
      sync_q[0] <= pin_i;
    end
  end

  genvar g;
  generate
    for (g = 1; g < SYNC; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sync_q[g] <= '0;
        end else begin
          sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  // one extra sample for the stability compare, and a fill tracker
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      vld_q  <= '0;
    end else begin
      hold_q <= sync_q[SYNC-1];
      vld_q  <= {vld_q[VLD_W-2:0], 1'b1};
    end
  end

  assign live_o    = sync_q[SYNC-1];
  assign code_o    = sync_q[SYNC-1];
  assign code_ok_o = vld_q[VLD_W-1] && (sync_q[SYNC-1] == hold_q);

endmodule

// File: rtl/sport_boot_fsm.sv
module sport_boot_fsm
  import sport_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] code_i,
  input  logic       code_ok_i,
  input  logic       ign_i,
  output logic       halt_o,
  output logic       enter_o,
  output logic       start_o
);

  boot_st_e st_q, st_d;
  logic     go;
  logic     enter;
  logic     start_q;

  always_comb begin
    st_d  = st_q;
    go    = 1'b0;
    enter = 1'b0;
    unique case (st_q)
      ST_INIT: begin
        if (ign_i) begin
          st_d = ST_RUN;
        end else if (code_ok_i) begin
          if (code_i == CODE_BOOT) begin
            st_d  = ST_BOOT;
            enter = 1'b1;
          end else begin
            st_d = ST_RUN;
          end
        end
      end
      ST_BOOT: begin
        if (!ign_i && code_ok_i && (code_i == CODE_GO)) begin
          st_d = ST_RUN;
          go   = 1'b1;
        end
      end
      ST_RUN:  st_d = ST_RUN;
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_INIT;
      start_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      start_q <= go;
    end
  end

  assign halt_o  = (st_q == ST_BOOT);
  assign enter_o = enter;
  assign start_o = start_q;

  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN) |=> (st_q == ST_RUN)); // R6

  AST_IGN_HOLDS_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BOOT && ign_i) |=> (st_q == ST_BOOT)); // R10

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q); // R8

endmodule

// File: rtl/sport_ctl_reg.sv
module sport_ctl_reg
  import sport_pkg::*;
#(
  parameter int unsigned          ADDR_W   = 8,
  parameter logic [ADDR_W-1:0]    REG_ADDR = 8'h24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              wign_i,
  input  logic [1:0]        wpm_i,
  input  logic [1:0]        wprio_i,
  input  logic [1:0]        live_i,
  input  logic              boot_i,
  input  logic              enter_i,
  output logic              ign_o,
  output logic [1:0]        pm_o,
  output logic [1:0]        prio_o,
  output logic [7:0]        rdata_o
);

  logic       hit;
  logic       wr_hit;
  logic       rd_hit;
  logic       ign_q;
  logic [1:0] pm_q, pm_d;
  logic       pm_en;
  logic [1:0] prio_q;
  logic [7:0] rdata_q, rdata_d;

  assign hit    = (addr_i == REG_ADDR);
  assign wr_hit = wr_i && hit;
  assign rd_hit = rd_i && hit;

  // port mode: forced on cold-boot entry, locked during cold boot
  always_comb begin
    pm_d  = pm_q;
    pm_en = 1'b0;
    if (enter_i) begin
      pm_d  = PM_SLAVE;
      pm_en = 1'b1;
    end else if (wr_hit && !boot_i) begin
      pm_d  = wpm_i;
      pm_en = 1'b1;
    end
  end

  always_comb begin
    rdata_d = '0;
    if (rd_hit) begin
      rdata_d[PIN_LSB +: 2] = live_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ign_q  <= 1'b0;
      prio_q <= '0;
    end else if (wr_hit) begin
      ign_q  <= wign_i;
      prio_q <= wprio_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pm_q <= PM_IN;
    end else if (pm_en) begin
      pm_q <= pm_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_d;
    end
  end

  assign ign_o   = ign_q;
  assign pm_o    = pm_q;
  assign prio_o  = prio_q;
  assign rdata_o = rdata_q;

  AST_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |=> (rdata_q == '0)); // R3

endmodule

// File: rtl/sport_ctl.sv
module sport_ctl
  import sport_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h24,
  parameter int unsigned       SYNC     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [1:0]        mode_pin,
  output logic [1:0]        port_mode,
  output logic [1:0]        irq_prio,
  output logic              boot_halt,
  output logic              start_zero
);

  logic [1:0] live;
  logic [1:0] code;
  logic       code_ok;
  logic       ign;
  logic       halt;
  logic       enter;
  logic       start;
  logic       unused_wbits;

  assign unused_wbits = ^bus_wdata[6:4];

  sport_pin_filter #(.W(2), .SYNC(SYNC)) u_filt (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_i     (mode_pin),
    .live_o    (live),
    .code_o    (code),
    .code_ok_o (code_ok)
  );

  sport_boot_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .code_i    (code),
    .code_ok_i (code_ok),
    .ign_i     (ign),
    .halt_o    (halt),
    .enter_o   (enter),
    .start_o   (start)
  );

  sport_ctl_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_i  (bus_addr),
    .wr_i    (bus_wr),
    .rd_i    (bus_rd),
    .wign_i  (bus_wdata[IGN_BIT]),
    .wpm_i   (bus_wdata[PM_LSB +: 2]),
    .wprio_i (bus_wdata[PRIO_LSB +: 2]),
    .live_i  (live),
    .boot_i  (halt),
    .enter_i (enter),
    .ign_o   (ign),
    .pm_o    (port_mode),
    .prio_o  (irq_prio),
    .rdata_o (bus_rdata)
  );

  assign boot_halt  = halt;
  assign start_zero = start;

  AST_START_LEAVES_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
    start_zero |-> (!boot_halt && $past(boot_halt))); // R7

  AST_BOOT_SLAVE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    boot_halt |-> (port_mode == PM_SLAVE)); // R9

endmodule

// File: tb/sport_ctl_bench.sv
module sport_ctl_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_addr;
  logic       bus_wr;
  logic       bus_rd;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [1:0] mode_pin;
  logic [1:0] port_mode;
  logic [1:0] irq_prio;
  logic       boot_halt;
  logic       start_zero;

  int checks   = 0;
  int failures = 0;
  int starts   = 0;
  bit done     = 0;

  always #5 clk = ~clk;

  sport_ctl u_sport_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .mode_pin   (mode_pin),
    .port_mode  (port_mode),
    .irq_prio   (irq_prio),
    .boot_halt  (boot_halt),
    .start_zero (start_zero)
  );

  // ---------------- behavioural reference ----------------
  localparam logic [7:0] RA = 8'h24;
  logic [1:0] hist[$];
  int         m_st;      // 0 undecided, 1 cold boot, 2 running
  bit         m_ign;
  logic [1:0] m_pm, m_prio;
  logic [7:0] m_rdata;
  bit         m_start;

  function automatic logic [1:0] pin_at(int i);
    if (i < 0 || i >= hist.size()) return 2'b00;
    return hist[i];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist.delete();
      m_st = 0; m_ign = 0; m_pm = 0; m_prio = 0; m_rdata = 0; m_start = 0;
    end else begin
      int sz;
      logic [1:0] c_new, c_old;
      bit settled, enter, go;
      int nst;
      sz      = hist.size();
      c_new   = pin_at(sz - 2);
      c_old   = pin_at(sz - 3);
      settled = (sz >= 3) && (c_new == c_old);
      enter = 0; go = 0; nst = m_st;
      if (m_st == 0) begin
        if (m_ign) nst = 2;
        else if (settled) begin
          if (c_new == 2'b01) begin nst = 1; enter = 1; end
          else nst = 2;
        end
      end else if (m_st == 1) begin
        if (!m_ign && settled && c_new == 2'b00) begin nst = 2; go = 1; end
      end
      m_rdata = (bus_rd && bus_addr == RA) ? {1'b0, c_new, 5'b0} : 8'h00;
      if (bus_wr && bus_addr == RA) begin
        if (!(m_st == 1)) m_pm = bus_wdata[3:2];
        m_ign  = bus_wdata[7];
        m_prio = bus_wdata[1:0];
      end
      if (enter) m_pm = 2'b10;
      m_start = go;
      m_st    = nst;
      hist.push_back(mode_pin);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R9 port_mode",  port_mode,  m_pm);
      chk("R2 irq_prio",   irq_prio,   m_prio);
      chk("R5 boot_halt",  boot_halt,  (m_st == 1));
      chk("R7 start_zero", start_zero, m_start);
      chk("R3 bus_rdata",  bus_rdata,  m_rdata);
      if (start_zero) starts++;
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] pins);
    @(negedge clk);
    rst_n = 0; mode_pin = pins;
    cyc(1);
    chk("R1 reset port_mode", port_mode, 0);
    chk("R1 reset irq_prio",  irq_prio,  0);
    chk("R1 reset halt",      boot_halt, 0);
    chk("R1 reset start",     start_zero, 0);
    chk("R1 reset rdata",     bus_rdata, 0);
    cyc(2);
    starts = 0;
    rst_n = 1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk);
    bus_addr = a; bus_rd = 1;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic pins(input logic [1:0] p);
    @(negedge clk);
    mode_pin = p;
  endtask

  initial begin
    rst_n = 0; bus_addr = 0; bus_wr = 0; bus_rd = 0; bus_wdata = 0; mode_pin = 0;

    // run 1: cold boot, with a port-mode write held across the entry edge
    bus_addr = RA; bus_wdata = 8'h04; bus_wr = 1;
    do_reset(2'b01);
    cyc(8);
    bus_wr = 0;
    cyc(1);
    chk("R5 halted after 01", boot_halt, 1);
    chk("R9 entry beats write", port_mode, 2'b10);
    wr(RA, 8'h0F);
    cyc(1);
    chk("R9 write locked in boot", port_mode, 2'b10);
    chk("R2 prio 3", irq_prio, 3);
    rd(RA);
    cyc(1);
    rd(8'h25);
    wr(8'h25, 8'h01);
    cyc(1);
    chk("R2 wrong address", irq_prio, 3);
    pins(2'b00); pins(2'b01);
    cyc(6);
    chk("R4 glitch ignored", boot_halt, 1);
    pins(2'b11);
    cyc(6);
    chk("R7 only 00 releases", boot_halt, 1);
    // release with a port-mode write held across the exit edge
    bus_addr = RA; bus_wdata = 8'h08; bus_wr = 1;
    pins(2'b00);
    cyc(6);
    bus_wr = 0;
    chk("R7 released", boot_halt, 0);
    chk("R8 one start", starts, 1);
    wr(RA, 8'h0C);
    pins(2'b01);
    cyc(8);
    pins(2'b00);
    cyc(8);
    chk("R8 no reentry", boot_halt, 0);
    chk("R8 still one start", starts, 1);
    rd(RA);
    cyc(2);

    // run 2: normal start
    do_reset(2'b10);
    cyc(8);
    chk("R6 run no halt", boot_halt, 0);
    wr(RA, 8'h0E);
    cyc(1);
    chk("R2 port_mode aux", port_mode, 2'b11);
    chk("R2 prio 2", irq_prio, 2);
    pins(2'b01);
    cyc(8);
    rd(RA);
    cyc(1);
    chk("R6 no start", starts, 0);
    chk("R6 still run", boot_halt, 0);

    // run 3: ignore bit during cold boot
    do_reset(2'b01);
    cyc(8);
    wr(RA, 8'h80);
    pins(2'b00);
    cyc(10);
    chk("R10 stays halted", boot_halt, 1);
    chk("R10 no start", starts, 0);

    // run 4: ignore bit before the first decision
    do_reset(2'b01);
    bus_addr = RA; bus_wdata = 8'h81; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
    cyc(8);
    chk("R10 undecided goes run", boot_halt, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule